// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a write-only slave on a three-wire serial link (active-low chip select, serial clock, serial data). It holds five 10-bit control words. A host lowers chip select, clocks in one 16-bit frame and raises chip select again. The frame carries a 2-bit operation code, a 4-bit register index and a 10-bit payload. Each field is sent least-significant bit first, and the fields are sent in that order: code, index, payload.

The block samples all three link pins into the system clock domain with a two-stage synchronizer. It detects serial clock rising edges and the chip-select rising edge there. A frame is committed only on the chip-select rising edge, and only when exactly 16 serial clock rising edges arrived while chip select was low. When the `opc_bypass` input is high, the operation code is ignored. When it is low, the code must be O0 = 0 and O1 = 1 (the first bit sent is 0, the second is 1). The committed payload appears on the parallel output of the addressed word. No path exists to read the words back.

Top module: `ser_cfg_port`

## Requirements
- R1: Frame bit k (k = 0 first) maps as follows. Bits 0..1 are O0 and O1. Bits 2..5 are the index, with the index LSB at bit 2. Bits 6..15 are the payload, with the payload LSB at bit 6.
- R2: Serial data is taken only on serial clock rising edges while chip select is low. Serial clock edges while chip select is high are not counted.
- R3: No output word changes while chip select is still low, even after a complete frame has been clocked in.
- R4: A frame with fewer than 16 serial clock rising edges changes no word.
- R5: A frame with more than 16 serial clock rising edges changes no word.
- R6: With `opc_bypass` high, a complete frame is committed whatever its operation code.
- R7: With `opc_bypass` low, a complete frame is committed only if O0 = 0 and O1 = 1. The codes 00, 11 and O0 = 1 with O1 = 0 are rejected.
- R8: Index 0 drives `mode_a`, 1 drives `mode_b`, 2 drives `gain`, 3 drives `black_lvl` and 4 drives `test_ctl`.
- R9: A frame with an index from 5 to 15 changes no word.
- R10: While `rst_n` is low, and after it is released, every word is 0 except `black_lvl`, which is 64.
- R11: Suppose chip select rises between two system clock rising edges. A committed word then takes its new value at the 4th system clock rising edge after that point, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, data sampled on its rising edge |
| sdata | input | 1 | Serial data |
| opc_bypass | input | 1 | High: operation code not checked |
| mode_a | output | 10 | Word at index 0 |
| mode_b | output | 10 | Word at index 1 |
| gain | output | 10 | Word at index 2 |
| black_lvl | output | 10 | Word at index 3 |
| test_ctl | output | 10 | Word at index 4 |

## Verification
Several checks run on every cycle. Words stay frozen unless a commit strobe fired on the previous cycle. A commit is only ever preceded by an edge count of exactly 16. With the bypass low, a commit always follows an accepted operation code. At most one word is written at a time, and the edge counter never passes its saturation value. Other behaviour can only be shown by the bench's scenarios. That covers the bit order inside each field, the index-to-output mapping, the rejection of short and long frames and of out-of-range indices, and the neglect of serial clock edges while chip select is high. It also covers the exact four-edge delay from the chip-select rise to the output change.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int OPC_BITS   = 2;
    localparam int ADDR_BITS  = 4;
    localparam int DATA_BITS  = 10;
    localparam int NUM_REGS   = 5;
    localparam int SYNC_STAGES = 2;

    localparam int ADDR_LSB = OPC_BITS;
    localparam int DATA_LSB = OPC_BITS + ADDR_BITS;
    localparam int CNT_W    = $clog2(FRAME_BITS + 2);

    // accepted operation code: first bit 0, second bit 1
    localparam logic [OPC_BITS-1:0] OPC_WRITE = 2'b10;

    localparam int IDX_MODE_A = 0;
    localparam int IDX_MODE_B = 1;
    localparam int IDX_GAIN   = 2;
    localparam int IDX_BLACK  = 3;
    localparam int IDX_TEST   = 4;

    localparam logic [DATA_BITS-1:0] BLACK_DEFAULT = DATA_BITS'(64);

endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ser_cfg_shifter.sv
module ser_cfg_shifter #(
    parameter int                  FRAME_BITS = 16,
    parameter int                  OPC_BITS   = 2,
    parameter int                  ADDR_BITS  = 4,
    parameter int                  DATA_BITS  = 10,
    parameter int                  CNT_W      = 5,
    parameter logic [OPC_BITS-1:0] OPC_WRITE  = 2'b10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_s,
    input  logic                 sck_s,
    input  logic                 sdata_s,
    input  logic                 op_s,
    output logic                 commit_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [OPC_BITS-1:0]  opc_o,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [DATA_BITS-1:0] data_o
);

    localparam int ADDR_LSB = OPC_BITS;
    localparam int DATA_LSB = OPC_BITS + ADDR_BITS;
    localparam int CNT_MAX  = FRAME_BITS + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

    typedef struct packed {
        logic [FRAME_BITS-1:0] sh;
        logic [CNT_W-1:0]      cnt;
        logic                  cs_last;
        logic                  sck_last;
        logic                  commit;
    } shf_t;

    shf_t shf_d, shf_q;
    logic full_frame;
    logic opc_ok;

    always_comb begin
        full_frame = (shf_q.cnt == CNT_FULL);
        opc_ok     = op_s || (shf_q.sh[OPC_BITS-1:0] == OPC_WRITE);

        shf_d          = shf_q;
        shf_d.commit   = 1'b0;
        shf_d.cs_last  = cs_n_s;
        shf_d.sck_last = sck_s;

        if (cs_n_s) begin
            shf_d.cnt = '0;
            if (!shf_q.cs_last) begin
                shf_d.commit = full_frame && opc_ok;
            end
        end else if (sck_s && !shf_q.sck_last) begin
            shf_d.sh = {sdata_s, shf_q.sh[FRAME_BITS-1:1]};
            if (shf_q.cnt != CNT_SAT) begin
                shf_d.cnt = shf_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q          <= '0;
            shf_q.cs_last  <= 1'b1;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign commit_o = shf_q.commit;
    assign cnt_o    = shf_q.cnt;
    assign opc_o    = shf_q.sh[OPC_BITS-1:0];
    assign addr_o   = shf_q.sh[ADDR_LSB +: ADDR_BITS];
    assign data_o   = shf_q.sh[DATA_LSB +: DATA_BITS];

endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
    parameter int                   DATA_BITS     = 10,
    parameter int                   ADDR_BITS     = 4,
    parameter int                   NUM_REGS      = 5,
    parameter int                   IDX_BLACK     = 3,
    parameter logic [DATA_BITS-1:0] BLACK_DEFAULT = 10'd64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit_i,
    input  logic [ADDR_BITS-1:0]               addr_i,
    input  logic [DATA_BITS-1:0]               data_i,
    output logic [NUM_REGS-1:0]                wr_en_o,
    output logic [NUM_REGS-1:0][DATA_BITS-1:0] regs_o
);

    typedef logic [NUM_REGS-1:0][DATA_BITS-1:0] bank_t;

    bank_t bank_d, bank_q;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
        assign wr_en_o[gi] = commit_i && (addr_i == ADDR_BITS'(gi));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en_o[i]) begin
                bank_d[i] = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q[i] <= (i == IDX_BLACK) ? BLACK_DEFAULT : '0;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_o = bank_q;

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import ser_cfg_pkg::*;
#(
    parameter int DATA_W = DATA_BITS,
    parameter int ADDR_W = ADDR_BITS,
    parameter int OPC_W  = OPC_BITS,
    parameter int FRM_W  = FRAME_BITS,
    parameter int SYNC_N = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdata,
    input  logic              opc_bypass,
    output logic [DATA_W-1:0] mode_a,
    output logic [DATA_W-1:0] mode_b,
    output logic [DATA_W-1:0] gain,
    output logic [DATA_W-1:0] black_lvl,
    output logic [DATA_W-1:0] test_ctl
);

    localparam int NREG = NUM_REGS;
    localparam int CW   = $clog2(FRM_W + 2);

    // synchronizer lanes: {op, sdata, sck, cs_n}; chip select idles high
    logic [3:0] pins_s;
    logic       cs_n_s, sck_s, sdata_s, op_s;

    logic                         commit_stb;
    logic [CW-1:0]                frm_cnt;
    logic [OPC_W-1:0]             frm_opc;
    logic [ADDR_W-1:0]            frm_addr;
    logic [DATA_W-1:0]            frm_data;
    logic [NREG-1:0]              wr_en;
    logic [NREG-1:0][DATA_W-1:0]  reg_q;

    ser_cfg_sync #(
        .W       (4),
        .STAGES  (SYNC_N),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({opc_bypass, sdata, sck, cs_n}),
        .sync_o  (pins_s)
    );

    assign cs_n_s  = pins_s[0];
    assign sck_s   = pins_s[1];
    assign sdata_s = pins_s[2];
    assign op_s    = pins_s[3];

    ser_cfg_shifter #(
        .FRAME_BITS (FRM_W),
        .OPC_BITS   (OPC_W),
        .ADDR_BITS  (ADDR_W),
        .DATA_BITS  (DATA_W),
        .CNT_W      (CW),
        .OPC_WRITE  (OPC_WRITE)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .sck_s    (sck_s),
        .sdata_s  (sdata_s),
        .op_s     (op_s),
        .commit_o (commit_stb),
        .cnt_o    (frm_cnt),
        .opc_o    (frm_opc),
        .addr_o   (frm_addr),
        .data_o   (frm_data)
    );

    ser_cfg_bank #(
        .DATA_BITS     (DATA_W),
        .ADDR_BITS     (ADDR_W),
        .NUM_REGS      (NREG),
        .IDX_BLACK     (IDX_BLACK),
        .BLACK_DEFAULT (DATA_W'(BLACK_DEFAULT))
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_stb),
        .addr_i   (frm_addr),
        .data_i   (frm_data),
        .wr_en_o  (wr_en),
        .regs_o   (reg_q)
    );

    assign mode_a    = reg_q[IDX_MODE_A];
    assign mode_b    = reg_q[IDX_MODE_B];
    assign gain      = reg_q[IDX_GAIN];
    assign black_lvl = reg_q[IDX_BLACK];
    assign test_ctl  = reg_q[IDX_TEST];

endmodule

// File: rtl/ser_cfg_port_chk.sv
module ser_cfg_port_chk
    import ser_cfg_pkg::*;
(
    input logic                                clk,
    input logic                                rst_n,
    input logic                                op_s,
    input logic                                commit,
    input logic [CNT_W-1:0]                    cnt,
    input logic [OPC_BITS-1:0]                 opcode,
    input logic [NUM_REGS-1:0]                 wr_en,
    input logic [NUM_REGS-1:0][DATA_BITS-1:0]  regs
);

    // R3: words move only on the cycle after a commit strobe
    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs));

    // R4 / R5: a commit is only ever preceded by a count of exactly one frame
    a_r4_r5_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(cnt) == CNT_W'(FRAME_BITS)));

    // R5: edge counter saturates one above the frame length
    a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_BITS + 1));

    // R7: with bypass low a commit needs the accepted operation code
    a_r7_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(op_s) || ($past(opcode) == OPC_WRITE)));

    // R9: at most one word written per cycle
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R10: defaults visible on the first edge after reset release
    a_r10_defaults: assert property (@(posedge clk)
        $rose(rst_n) |-> (regs[IDX_BLACK] == BLACK_DEFAULT &&
                          regs[IDX_MODE_A] == '0 && regs[IDX_MODE_B] == '0 &&
                          regs[IDX_GAIN] == '0 && regs[IDX_TEST] == '0));

endmodule

bind ser_cfg_port ser_cfg_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_s   (op_s),
    .commit (commit_stb),
    .cnt    (frm_cnt),
    .opcode (frm_opc),
    .wr_en  (wr_en),
    .regs   (reg_q)
);

// File: tb/test_ser_cfg_port.sv
module test_ser_cfg_port;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cs_n, sck, sdata, opb;
    logic [9:0] mode_a, mode_b, gain, black_lvl, test_ctl;

    ser_cfg_port i_ser_cfg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdata(sdata),
        .opc_bypass(opb), .mode_a(mode_a), .mode_b(mode_b), .gain(gain),
        .black_lvl(black_lvl), .test_ctl(test_ctl)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int expv[5];
    int snap[5];
    int pend_cnt = 0;
    int pend_addr = 0;
    int pend_data = 0;

    function automatic int actv(int i);
        case (i)
            0: return int'(mode_a);
            1: return int'(mode_b);
            2: return int'(gain);
            3: return int'(black_lvl);
            default: return int'(test_ctl);
        endcase
    endfunction

    function automatic logic [15:0] mk(logic [1:0] opc, int addr, int data);
        return {data[9:0], addr[3:0], opc};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic take_snap();
        for (int i = 0; i < 5; i++) snap[i] = actv(i);
    endtask

    task automatic chk_unchanged(string tag);
        for (int i = 0; i < 5; i++) chk(actv(i) == snap[i], tag, actv(i), snap[i]);
    endtask

    // reference model: a pending write lands on the 4th posedge after CS rise
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) expv[i] = (i == 3) ? 64 : 0;
            pend_cnt = 0;
        end else if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) expv[pend_addr] = pend_data;
        end
    end

    // R11 and everything else: every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 5; i++) begin
                tests++;
                if (actv(i) != expv[i]) begin
                    fails++;
                    $display("FAIL R11 cycle compare reg%0d: actual %0d expected %0d",
                             i, actv(i), expv[i]);
                end
            end
        end
    end

    task automatic send(int nbits, logic [15:0] w);
        int addr = int'(w[5:2]);
        int data = int'(w[15:6]);
        bit acc  = (nbits == 16) && (opb || w[1:0] == 2'b10) && (addr < 5);
        int old  = (addr < 5) ? actv(addr) : 0;
        cs_n = 1'b0;
        wait_clk(4);
        for (int b = 0; b < nbits; b++) begin
            sck = 1'b0;
            sdata = (b < 16) ? w[b] : 1'b0;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
        end
        sck = 1'b0;
        wait_clk(6);
        if (addr < 5)
            chk(actv(addr) == old, "R3 no change before CS rise", actv(addr), old);
        cs_n = 1'b1;
        if (acc) begin
            pend_addr = addr;
            pend_data = data;
            pend_cnt  = 4;
        end
        wait_clk(3);
        if (acc) chk(actv(addr) == old, "R11 old value after 3 edges", actv(addr), old);
        wait_clk(1);
        if (acc) chk(actv(addr) == data, "R11 new value at 4th edge", actv(addr), data);
        wait_clk(4);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdata = 1'b0; opb = 1'b1;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R10 reset values
        chk(mode_a == 0, "R10 mode_a default", mode_a, 0);
        chk(mode_b == 0, "R10 mode_b default", mode_b, 0);
        chk(gain == 0, "R10 gain default", gain, 0);
        chk(black_lvl == 64, "R10 black_lvl default", black_lvl, 64);
        chk(test_ctl == 0, "R10 test_ctl default", test_ctl, 0);

        // R6: bypass high, code 00 still written
        send(16, mk(2'b00, 2, 10'h155));
        chk(gain == 10'h155, "R6 bypass write gain", gain, 10'h155);

        // R1 / R8: every index with a pattern touching both payload ends
        for (int a = 0; a < 5; a++) begin
            int d = 10'h201 | (a << 3);
            send(16, mk(2'b11, a, d));
            chk(actv(a) == d, "R1 R8 index to output", actv(a), d);
        end

        // R7: bypass low, accepted code O0=0 O1=1
        opb = 1'b0;
        wait_clk(4);
        send(16, mk(2'b10, 0, 10'h3AA));
        chk(mode_a == 10'h3AA, "R7 accepted code", mode_a, 10'h3AA);
        take_snap();
        send(16, mk(2'b00, 1, 10'h0F0));
        send(16, mk(2'b11, 1, 10'h0F0));
        send(16, mk(2'b01, 1, 10'h0F0));
        chk_unchanged("R7 rejected codes");

        // R4: short frames
        opb = 1'b1;
        wait_clk(4);
        take_snap();
        send(15, mk(2'b10, 2, 10'h0AB));
        send(1, mk(2'b10, 2, 10'h0AB));
        chk_unchanged("R4 short frame");

        // R5: long frames
        send(17, mk(2'b10, 2, 10'h0CD));
        send(20, mk(2'b10, 4, 10'h0CD));
        chk_unchanged("R5 long frame");

        // R9: out-of-range index
        send(16, mk(2'b10, 5, 10'h3FF));
        send(16, mk(2'b10, 15, 10'h3FF));
        chk_unchanged("R9 index above 4");

        // R2: serial clock pulses with chip select high are not counted
        for (int k = 0; k < 5; k++) begin
            sck = 1'b1; wait_clk(4);
            sck = 1'b0; wait_clk(4);
        end
        send(16, mk(2'b10, 4, 10'h2C3));
        chk(test_ctl == 10'h2C3, "R2 idle clock ignored", test_ctl, 10'h2C3);

        // R10: reset after writes
        rst_n = 1'b0;
        wait_clk(2);
        chk(black_lvl == 64, "R10 black_lvl in reset", black_lvl, 64);
        chk(gain == 0, "R10 gain in reset", gain, 0);
        rst_n = 1'b1;
        wait_clk(2);
        chk(test_ctl == 0, "R10 test_ctl after reset", test_ctl, 0);
        chk(mode_a == 0, "R10 mode_a after reset", mode_a, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule